// File: doc/BRIEF.md
# Timed Up/Down Power Rail Sequencer

This block switches a set of supply-rail enables and one active-low system reset line on and off in a programmed order. A single shared counter moves one step per slow timebase tick (nominally 1 kHz). A power-up request starts the count at zero and runs it upward. A power-down request starts the count at its top value and runs it downward. Each channel owns a delay value. Its output turns on when the rising count goes past that value, and turns off when the falling count goes below it. The same delay table therefore gives a shutdown order that is the exact reverse of the startup order.

The channels are ordered as follows: one shared enable for the low-dropout regulators, a parameterised number of buck converter enables, and the reset line last. The delays come either from a parameter table or from a configuration input port, and a parameter selects which. A request in the opposite direction during a sequence turns the count around from where it is. Busy and done flags report the progress of the sequence.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is held and after it is released, every regulator enable is low, the system reset line is low, and busy and done are both low.
- R2: A power-up request taken while idle loads the count with 0 and raises busy. A channel with delay d turns on at the (d+1)-th advancing tick. A channel whose delay is 63 never turns on during power-up.
- R3: A power-down request taken while idle loads the count with 63 and raises busy. A channel with delay d turns off at the (64-d)-th advancing tick. A channel whose delay is 0 never turns off during power-down.
- R4: Outputs change only on a clock edge where a tick advances a running sequence. While counting up, outputs only turn on. While counting down, outputs only turn off.
- R5: A sequence ends on the edge where the count reaches 63 (up) or 0 (down). On that edge busy falls and done rises. Done stays high until the next accepted request.
- R6: While busy, a request in the opposite direction keeps the current count and reverses the direction. A request in the same direction is ignored.
- R7: When both requests arrive in the same cycle, the power-down request wins.
- R8: A tick in the same cycle as an accepted request does not advance the count. Ticks while idle have no effect.
- R9: The delay of channel i sits in bits [6i+5:6i] of the delay vector. Channel 0 is the LDO enable, channels 1 to 3 are buck enables 0 to 2, and channel 4 is the reset line. The FROM_PORT parameter chooses between the configuration port (1) and the DEFAULT_DELAYS parameter (0).
- R10: If a reversal is requested while the count already holds the end value of the new direction, the sequence finishes at once: busy falls and done rises on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase pulse, one per step |
| pwr_up_i | input | 1 | Power-up request pulse |
| pwr_dn_i | input | 1 | Power-down request pulse |
| delay_cfg_i | input | (N_BUCK+2)*CNT_W | Packed per-channel delays, used when FROM_PORT=1 |
| ldo_en_o | output | 1 | Shared LDO enable |
| buck_en_o | output | N_BUCK | Buck converter enables |
| sys_rst_n_o | output | 1 | Active-low system reset |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | The last sequence reached its end value |

## Verification
Every result is registered once. An accepted request or an advancing tick seen at one rising edge shows up on the enables, busy and done just after that same edge. No output moves on a cycle with no advancing tick or accepted request. The driver applies inputs at the falling edge and pushes the expected state for the coming edge into a queue. The monitor pops that entry 5 ns after the rising edge, so each comparison lands exactly one register stage after its stimulus.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/rseq_timer.sv
module rseq_timer
  import rseq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             up_req_i,
  input  logic             dn_req_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output dir_e             dir_o,
  output logic             adv_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  logic [CNT_W-1:0] cnt_q;
  dir_e             dir_q;
  logic             busy_q, done_q;
  logic             take_dn, take_up, take_any;
  dir_e             req_dir;
  logic [CNT_W-1:0] step_val;

  function automatic logic [CNT_W-1:0] end_of(dir_e d);
    return (d == DIR_UP) ? CNT_MAX : CNT_MIN;
  endfunction

  always_comb begin
    take_dn  = dn_req_i && !(busy_q && dir_q == DIR_DOWN);
    take_up  = up_req_i && !dn_req_i && !(busy_q && dir_q == DIR_UP);
    take_any = take_dn || take_up;
    req_dir  = take_dn ? DIR_DOWN : DIR_UP;
    step_val = (dir_q == DIR_UP) ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CNT_MIN;
      dir_q  <= DIR_DOWN;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (take_any) begin
      dir_q  <= req_dir;
      done_q <= 1'b0;
      if (busy_q) begin
        if (cnt_q == end_of(req_dir)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else begin
        cnt_q  <= (req_dir == DIR_UP) ? CNT_MIN : CNT_MAX;
        busy_q <= 1'b1;
      end
    end else if (tick_i && busy_q) begin
      cnt_q <= step_val;
      if (step_val == end_of(dir_q)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = step_val;
  assign dir_o     = dir_q;
  assign adv_o     = tick_i && busy_q && !take_any;
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (adv_o && dir_q == DIR_UP) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (adv_o && dir_q == DIR_DOWN) |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R3
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (cnt_q == CNT_MIN || cnt_q == CNT_MAX)); // R5
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && done_q)); // R5
  AST_REVERSE_KEEPS_CNT: assert property (@(posedge clk) disable iff (rst)
    (busy_q && ((dir_q == DIR_UP && dn_req_i) ||
                (dir_q == DIR_DOWN && up_req_i && !dn_req_i)))
    |=> cnt_q == $past(cnt_q)); // R6
  AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !up_req_i && !dn_req_i) |=> $stable(cnt_q) && !busy_q); // R8
endmodule

// File: rtl/rseq_delay_src.sv
module rseq_delay_src #(
  parameter int                     CNT_W     = 6,
  parameter int                     N_CH      = 5,
  parameter bit                     FROM_PORT = 1'b0,
  parameter logic [N_CH*CNT_W-1:0]  DEFAULTS  = '0
) (
  input  logic [N_CH*CNT_W-1:0] cfg_i,
  output logic [N_CH*CNT_W-1:0] thr_o
);
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_sel
    if (FROM_PORT) begin : g_port
      assign thr_o[ch*CNT_W +: CNT_W] = cfg_i[ch*CNT_W +: CNT_W];
    end else begin : g_param
      assign thr_o[ch*CNT_W +: CNT_W] =
        cfg_i[ch*CNT_W +: CNT_W] & '0 | DEFAULTS[ch*CNT_W +: CNT_W];
    end
  end
endmodule

// File: rtl/rseq_channel.sv
module rseq_channel
  import rseq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  dir_e             dir_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             en_o
);
  logic en_q;
  logic above, below;

  always_comb begin
    above = cnt_nxt_i > thr_i;
    below = cnt_nxt_i < thr_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else if (adv_i) begin
      if (dir_i == DIR_UP) en_q <= en_q | above;
      else                 en_q <= en_q & ~below;
    end
  end

  assign en_o = en_q;

  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(en_q)); // R4
  AST_UP_NO_FALL: assert property (@(posedge clk) disable iff (rst)
    (adv_i && dir_i == DIR_UP) |=> !$fell(en_q)); // R4
  AST_DOWN_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (adv_i && dir_i == DIR_DOWN) |=> !$rose(en_q)); // R4
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rseq_pkg::*;
#(
  parameter int   CNT_W     = 6,
  parameter int   N_BUCK    = 3,
  parameter bit   FROM_PORT = 1'b0,
  parameter logic [(N_BUCK+2)*CNT_W-1:0] DEFAULT_DELAYS =
    {6'd10, 6'd8, 6'd6, 6'd4, 6'd2}
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick_i,
  input  logic                        pwr_up_i,
  input  logic                        pwr_dn_i,
  input  logic [(N_BUCK+2)*CNT_W-1:0] delay_cfg_i,
  output logic                        ldo_en_o,
  output logic [N_BUCK-1:0]           buck_en_o,
  output logic                        sys_rst_n_o,
  output logic                        busy_o,
  output logic                        done_o
);
  localparam int N_CH   = N_BUCK + 2;
  localparam int RST_CH = N_CH - 1;

  logic [CNT_W-1:0]      cnt, cnt_nxt;
  dir_e                  dir;
  logic                  adv;
  logic [N_CH*CNT_W-1:0] thr;
  logic [N_CH-1:0]       en;

  rseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .up_req_i  (pwr_up_i),
    .dn_req_i  (pwr_dn_i),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .dir_o     (dir),
    .adv_o     (adv),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  rseq_delay_src #(
    .CNT_W     (CNT_W),
    .N_CH      (N_CH),
    .FROM_PORT (FROM_PORT),
    .DEFAULTS  (DEFAULT_DELAYS)
  ) u_dly (
    .cfg_i (delay_cfg_i),
    .thr_o (thr)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    rseq_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .adv_i     (adv),
      .dir_i     (dir),
      .cnt_nxt_i (cnt_nxt),
      .thr_i     (thr[ch*CNT_W +: CNT_W]),
      .en_o      (en[ch])
    );
  end

  assign ldo_en_o    = en[0];
  assign buck_en_o   = en[N_BUCK:1];
  assign sys_rst_n_o = en[RST_CH];

  AST_UP_START_LOADS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && pwr_up_i && !pwr_dn_i) |=> busy_o && cnt == '0); // R2
  AST_DN_START_LOADS_MAX: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && pwr_dn_i) |=> busy_o && dir == DIR_DOWN && cnt == {CNT_W{1'b1}}); // R7
  AST_IDLE_OUTS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !pwr_up_i && !pwr_dn_i) |=> $stable(en)); // R8
endmodule

// File: tb/test_rail_sequencer.sv
module test_rail_sequencer;
  localparam int W  = 6;
  localparam int NB = 3;
  localparam int NC = NB + 2;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, up = 1'b0, dn = 1'b0;
  logic [NC*W-1:0] cfg;
  logic ldo, srst, busy, done;
  logic [NB-1:0] buck;
  logic ldo_d, srst_d, busy_d, done_d;
  logic [NB-1:0] buck_d;

  int checks = 0, errors = 0;

  typedef struct {
    logic [NC-1:0] en;
    logic          busy;
    logic          done;
    string         tag;
  } exp_t;
  exp_t q[$];

  int            m_cnt;
  bit            m_up, m_run, m_done;
  logic [NC-1:0] m_en;

  rail_sequencer #(.CNT_W(W), .N_BUCK(NB), .FROM_PORT(1'b1)) i_rail_sequencer (
    .clk(clk), .rst(rst), .tick_i(tick), .pwr_up_i(up), .pwr_dn_i(dn),
    .delay_cfg_i(cfg), .ldo_en_o(ldo), .buck_en_o(buck),
    .sys_rst_n_o(srst), .busy_o(busy), .done_o(done));

  rail_sequencer #(.CNT_W(W), .N_BUCK(NB)) i_rail_sequencer_def (
    .clk(clk), .rst(rst), .tick_i(tick), .pwr_up_i(up), .pwr_dn_i(dn),
    .delay_cfg_i(cfg), .ldo_en_o(ldo_d), .buck_en_o(buck_d),
    .sys_rst_n_o(srst_d), .busy_o(busy_d), .done_o(done_d));

  always #10 clk = ~clk;

  function automatic int thr(int i);
    return int'(cfg[i*W +: W]);
  endfunction

  task automatic push(input string tag);
    exp_t e;
    e.en = m_en; e.busy = m_run; e.done = m_done; e.tag = tag;
    q.push_back(e);
  endtask

  // Driver: applies one cycle of stimulus and queues the state expected after that edge
  task automatic step(input bit u, input bit d, input bit t, input string tag);
    bit acc_d, acc_u, nu;
    up = u; dn = d; tick = t;
    acc_d = d && !(m_run && !m_up);
    acc_u = u && !d && !(m_run && m_up);
    if (acc_d || acc_u) begin
      nu = acc_u;
      m_up = nu; m_done = 1'b0;
      if (m_run) begin
        if (m_cnt == (nu ? 63 : 0)) begin m_run = 1'b0; m_done = 1'b1; end
      end else begin
        m_cnt = nu ? 0 : 63; m_run = 1'b1;
      end
    end else if (t && m_run) begin
      m_cnt = m_up ? m_cnt + 1 : m_cnt - 1;
      for (int i = 0; i < NC; i++) begin
        if (m_up && m_cnt > thr(i)) m_en[i] = 1'b1;
        if (!m_up && m_cnt < thr(i)) m_en[i] = 1'b0;
      end
      if (m_cnt == (m_up ? 63 : 0)) begin m_run = 1'b0; m_done = 1'b1; end
    end
    push(tag);
    @(posedge clk);
    @(negedge clk);
    up = 1'b0; dn = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b1, tag);
  endtask

  // Monitor: compares one queued item per clock, away from the edge
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({srst, buck, ldo} !== e.en || busy !== e.busy || done !== e.done) begin
        errors++;
        $display("FAIL %s: got en=%b busy=%b done=%b expected en=%b busy=%b done=%b",
                 e.tag, {srst, buck, ldo}, busy, done, e.en, e.busy, e.done);
      end
    end
  end

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cfg = {6'd40, 6'd30, 6'd12, 6'd5, 6'd0};
    m_cnt = 0; m_up = 1'b0; m_run = 1'b0; m_done = 1'b0; m_en = '0;
    @(negedge clk);
    push("R1 in reset");
    @(posedge clk); @(negedge clk);
    push("R1 in reset");
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    step(1'b0, 1'b0, 1'b0, "R1 after reset");
    ticks(3, "R8 idle ticks");

    // R2, R4, R5: full power-up, with gaps between ticks
    step(1'b1, 1'b0, 1'b0, "R2 start");
    for (int k = 1; k <= 70; k++) begin
      step(1'b0, 1'b0, 1'b1, "R2 R5 up");
      if (k % 4 == 0) step(1'b0, 1'b0, 1'b0, "R4 no tick");
      if (k == 5) begin
        checks++;
        if ({srst_d, buck_d, ldo_d} !== 5'b00011) begin
          errors++;
          $display("FAIL R9 default delays: got %b expected %b",
                   {srst_d, buck_d, ldo_d}, 5'b00011);
        end
      end
    end

    // R3, R4, R5: full power-down
    step(1'b0, 1'b1, 1'b0, "R3 start");
    for (int k = 1; k <= 70; k++) begin
      step(1'b0, 1'b0, 1'b1, "R3 R5 down");
      if (k % 5 == 0) step(1'b0, 1'b0, 1'b0, "R4 no tick");
    end

    // R6, R8: same-direction ignored, opposite reverses, tick in accept cycle dropped
    step(1'b1, 1'b0, 1'b0, "R2 start");
    ticks(20, "R2 up");
    step(1'b1, 1'b0, 1'b1, "R6 same dir ignored");
    step(1'b0, 1'b1, 1'b1, "R6 R8 reverse to down");
    ticks(8, "R6 down after reverse");
    step(1'b1, 1'b0, 1'b1, "R6 R8 reverse to up");
    ticks(70, "R6 up after reverse");

    // R7: simultaneous requests
    step(1'b1, 1'b1, 1'b0, "R7 both idle");
    ticks(3, "R7 down");
    step(1'b1, 1'b1, 1'b1, "R7 both while down");
    ticks(70, "R7 down");

    // R10: reversal at the end value of the new direction
    step(1'b1, 1'b0, 1'b0, "R10 up start");
    step(1'b0, 1'b1, 1'b0, "R10 reverse at 0");
    step(1'b0, 1'b1, 1'b0, "R10 down start");
    step(1'b1, 1'b0, 1'b0, "R10 reverse at 63");
    ticks(2, "R8 idle after R10");

    // R9 with R2/R3 boundaries: delays 0 and 63 on port
    cfg = {6'd63, 6'd0, 6'd1, 6'd62, 6'd63};
    step(1'b0, 1'b1, 1'b0, "R3 clear");
    ticks(70, "R3 clear");
    step(1'b1, 1'b0, 1'b0, "R9 R2 start");
    ticks(70, "R9 R2 boundary up");
    step(1'b0, 1'b1, 1'b0, "R9 R3 start");
    ticks(70, "R9 R3 boundary down");

    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule